// File: doc/BRIEF.md
# Dual-Mode Framed Serial Register Port

This block is the serial slave interface of a converter-style device. Through it a host writes a 24-bit control register and a 24-bit calibration register, and it reads back either the control register or the live conversion word supplied by the converter core. A write transfer is framed by one active-low strobe and a read transfer by a second one. An address input, captured when the frame opens, selects the control register (low) or the data/calibration side (high). Words travel MSB first: input bits are taken on the rising serial clock edge, and output bits move on the falling edge.

A static mode input chooses how the serial clock is made. In self-clocked mode the port drives the clock pin itself, at one quarter of the master clock. It starts once a frame strobe goes low and stops after the 24th bit or when the strobe is released. In external mode the pin is an input. The host may clock continuously or in bursts with pauses, and the port keeps its bit position across the pauses. The strobes, the external clock and the synchronisation input pass through two-flop synchronisers. A falling edge on the synchronisation input produces a fixed-length reset pulse for the downstream filter.

Top module: `framed_reg_port`

## Requirements
- R1: After reset the control and calibration registers read zero, and the clock-enable, data-enable and filter-reset outputs are low.
- R2: With the mode input low the port never drives the serial clock pin (sclk_oe stays low). Only edges on sclk_in move data.
- R3: With the mode input high and a frame strobe low, the port drives exactly 24 rising clock edges spaced 4 master-clock cycles apart, each high and low phase lasting 2 cycles. It then stops driving the pin while the strobe is still low.
- R4: In self-clocked mode, releasing the active strobe before the word completes stops driving the clock pin.
- R5: A write frame with the address input low loads the 24 bits taken on rising edges into the control register, first bit into bit 23.
- R6: A write frame with the address input high loads the calibration register instead and leaves the control register untouched. The address is taken when the frame opens.
- R7: A read frame sends, MSB first, the control register when the address input is low and conv_data when it is high. Bit 23 is on sdo before the first rising edge, and each falling edge presents the next bit.
- R8: sdo_oe is high only during a read frame and is low whenever the read strobe is high.
- R9: A write frame released before 24 bits have arrived changes no register.
- R10: In external mode the clock may stop for any number of cycles mid-word without losing the bit position.
- R11: Rising edges after the 24th within one write frame are ignored, so the register holds the first 24 bits.
- R12: A falling edge on sync_n raises filt_rst for exactly 4 master-clock cycles. Holding sync_n low does not retrigger it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_self | input | 1 | 1: self-clocked, 0: external clock |
| addr_sel | input | 1 | 0: control register, 1: data/calibration side |
| tx_frame_n | input | 1 | Active-low write frame strobe |
| rx_frame_n | input | 1 | Active-low read frame strobe |
| sclk_in | input | 1 | Serial clock from host (external mode) |
| sclk_out | output | 1 | Generated serial clock (self-clocked mode) |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sdi | input | 1 | Serial write data |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for serial read data |
| sync_n | input | 1 | Active-low filter synchronisation request |
| filt_rst | output | 1 | Reset pulse to the downstream filter |
| conv_data | input | 24 | Conversion word from the converter core |
| ctrl_word | output | 24 | Control register contents |
| cal_word | output | 24 | Calibration register contents |

## Verification
On every cycle the assertions check that the clock pin stays undriven in external mode and that the generated clock falls back low once its run condition drops. They also check that the bit counter never passes 24, that sdo moves only on a falling edge, that the data enable drops after the read strobe rises, that the control register changes only on a completed word, and that a sync falling edge starts the pulse. Only the bench scenarios show that whole words arrive in the right register and the right bit order. The same holds for the exact count and spacing of generated clock edges, for discarding of short frames, for tolerance of clock gaps, for the ignoring of surplus bits and for the pulse length.

// File: rtl/frp_pkg.sv
package frp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } xfer_st_e;
endpackage

// File: rtl/frp_bit_sync.sv
module frp_bit_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = async_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.s1 <= RST_VAL;
            r_q.s2 <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_o = r_q.s2;
endmodule

// File: rtl/frp_sclk_gen.sv
module frp_sclk_gen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             sclk;
    } gen_t;

    gen_t r_q, r_d;
    logic toggle;

    always_comb begin
        r_d    = r_q;
        toggle = run_i && (r_q.div == DIV_LAST);
        if (!run_i) begin
            r_d.div  = '0;
            r_d.sclk = 1'b0;
        end else if (toggle) begin
            r_d.div  = '0;
            r_d.sclk = ~r_q.sclk;
        end else begin
            r_d.div = r_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk_o = r_q.sclk;
    assign rise_o = toggle && !r_q.sclk;
    assign fall_o = toggle && r_q.sclk;

    // R3: a stopped generator parks its clock low
    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_o);
endmodule

// File: rtl/frp_sync_pulse.sv
module frp_sync_pulse #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n_s,
    output logic pulse_o
);
    localparam int PC_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic            prev;
        logic [PC_W-1:0] cnt;
    } pls_t;

    pls_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.prev = sync_n_s;
        if (r_q.prev && !sync_n_s) begin
            r_d.cnt = PC_W'(PULSE_CYC);
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.prev <= 1'b1;
            r_q.cnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pulse_o = (r_q.cnt != '0);

    // R12: a falling sync edge starts the filter reset pulse
    p_pulse_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.prev && !sync_n_s) |=> pulse_o);
endmodule

// File: rtl/frp_engine.sv
module frp_engine
    import frp_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_self,
    input  logic              addr_sel,
    input  logic              tx_s,
    input  logic              rx_s,
    input  logic              sclk_s,
    input  logic              sdi,
    input  logic [WORD_W-1:0] conv_data,
    input  logic              g_sclk,
    input  logic              g_rise,
    input  logic              g_fall,
    output logic              run_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] cal_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        xfer_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic              addr_hi;
        logic              sclk_p;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] cal;
    } eng_t;

    eng_t r_q, r_d;
    logic rise, fall, full, done_self, commit_ctrl;
    logic [WORD_W-1:0] shifted_in;

    always_comb begin
        r_d         = r_q;
        r_d.sclk_p  = sclk_s;
        rise        = mode_self ? g_rise : (sclk_s && !r_q.sclk_p);
        fall        = mode_self ? g_fall : (!sclk_s && r_q.sclk_p);
        full        = (r_q.cnt == CNT_FULL);
        done_self   = full && !g_sclk;
        shifted_in  = {r_q.sh[WORD_W-2:0], sdi};
        commit_ctrl = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (!tx_s) begin
                    r_d.st      = ST_WRITE;
                    r_d.cnt     = '0;
                    r_d.addr_hi = addr_sel;
                    r_d.sh      = '0;
                end else if (!rx_s) begin
                    r_d.st      = ST_READ;
                    r_d.cnt     = '0;
                    r_d.addr_hi = addr_sel;
                    r_d.sh      = addr_sel ? conv_data : r_q.ctrl;
                end
            end
            ST_WRITE: begin
                if (tx_s) begin
                    r_d.st = ST_IDLE;
                end else if (rise && !full) begin
                    r_d.sh  = shifted_in;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_LAST) begin
                        if (r_q.addr_hi) begin
                            r_d.cal = shifted_in;
                        end else begin
                            r_d.ctrl    = shifted_in;
                            commit_ctrl = 1'b1;
                        end
                    end
                end
            end
            ST_READ: begin
                if (rx_s) begin
                    r_d.st = ST_IDLE;
                end else begin
                    if (rise && !full) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                    if (fall && (r_q.cnt != '0)) begin
                        r_d.sh = {r_q.sh[WORD_W-2:0], 1'b0};
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.addr_hi <= 1'b0;
            r_q.sclk_p  <= 1'b0;
            r_q.sh      <= '0;
            r_q.ctrl    <= '0;
            r_q.cal     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_o    = mode_self && (r_q.st != ST_IDLE) && !done_self;
    assign sdo_oe_o = (r_q.st == ST_READ);
    assign sdo_o    = r_q.sh[WORD_W-1] && sdo_oe_o;
    assign ctrl_o   = r_q.ctrl;
    assign cal_o    = r_q.cal;

    // R3: the bit counter never passes one word
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_FULL);

    // R7: read data moves only on a falling serial edge
    p_sdo_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && !fall) |=> (!sdo_oe_o || $stable(sdo_o)));

    // R8: a released read strobe removes the data drive next cycle
    p_sdo_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_s |=> !sdo_oe_o);

    // R9: control register changes only on a completed word
    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_ctrl |=> $stable(ctrl_o));
endmodule

// File: rtl/framed_reg_port.sv
module framed_reg_port #(
    parameter int WORD_W    = 24,
    parameter int HALF_CYC  = 2,
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_self,
    input  logic              addr_sel,
    input  logic              tx_frame_n,
    input  logic              rx_frame_n,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sync_n,
    output logic              filt_rst,
    input  logic [WORD_W-1:0] conv_data,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] cal_word
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_in, synced;
    logic tx_s, rx_s, sclk_s, sync_s;
    logic run, g_sclk, g_rise, g_fall;

    assign raw_in = {sync_n, rx_frame_n, tx_frame_n, sclk_in};
    assign sclk_s = synced[0];
    assign tx_s   = synced[1];
    assign rx_s   = synced[2];
    assign sync_s = synced[3];

    frp_bit_sync #(.W(NSYNC), .RST_VAL(4'b1110)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(synced)
    );

    frp_sclk_gen #(.HALF_CYC(HALF_CYC)) u_gen (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .sclk_o(g_sclk), .rise_o(g_rise), .fall_o(g_fall)
    );

    frp_engine #(.WORD_W(WORD_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .mode_self(mode_self), .addr_sel(addr_sel),
        .tx_s(tx_s), .rx_s(rx_s), .sclk_s(sclk_s), .sdi(sdi),
        .conv_data(conv_data), .g_sclk(g_sclk), .g_rise(g_rise), .g_fall(g_fall),
        .run_o(run), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .ctrl_o(ctrl_word), .cal_o(cal_word)
    );

    frp_sync_pulse #(.PULSE_CYC(PULSE_CYC)) u_pls (
        .clk(clk), .rst_n(rst_n), .sync_n_s(sync_s), .pulse_o(filt_rst)
    );

    assign sclk_out = g_sclk;
    assign sclk_oe  = run;

    // R2: external mode never drives the clock pin
    p_oe_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_self |-> !sclk_oe);
endmodule

// File: tb/framed_reg_port_tb_top.sv
module framed_reg_port_tb_top;
    localparam int W  = 24;
    localparam int HP = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_self = 1'b0, addr_sel = 1'b0;
    logic tx_frame_n = 1'b1, rx_frame_n = 1'b1, sclk_in = 1'b0;
    logic sdi = 1'b0, sync_n = 1'b1;
    logic [W-1:0] conv_data = '0;
    logic sclk_out, sclk_oe, sdo, sdo_oe, filt_rst;
    logic [W-1:0] ctrl_word, cal_word;

    int checks = 0, errs = 0;
    bit finished = 0;
    logic [W-1:0] exp_ctrl = '0, exp_cal = '0;
    int n_rise, min_gap, max_gap;
    bit oe_seen;

    always #5 clk = ~clk;

    framed_reg_port dut_i (
        .clk(clk), .rst_n(rst_n), .mode_self(mode_self), .addr_sel(addr_sel),
        .tx_frame_n(tx_frame_n), .rx_frame_n(rx_frame_n), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
        .sdo_oe(sdo_oe), .sync_n(sync_n), .filt_rst(filt_rst),
        .conv_data(conv_data), .ctrl_word(ctrl_word), .cal_word(cal_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] exp_write(input logic [W-1:0] w);
        return w;
    endfunction

    // external-clock write; bit i>=W is filler that must be ignored
    task automatic ext_wr(input logic a, input logic [W-1:0] w, input int nbits, input int gap);
        addr_sel = a; cyc(2);
        tx_frame_n = 1'b0; cyc(4);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < W) ? w[W-1-i] : i[0];
            cyc(HP); sclk_in = 1'b1; cyc(HP); sclk_in = 1'b0;
            if (gap > 0 && (i % 5) == 4) cyc(gap);
        end
        cyc(4); tx_frame_n = 1'b1; cyc(6);
    endtask

    task automatic ext_rd(input logic a, output logic [W-1:0] w);
        addr_sel = a; cyc(2);
        rx_frame_n = 1'b0; cyc(6);
        oe_seen = sdo_oe;
        for (int i = 0; i < W; i++) begin
            cyc(HP); w[W-1-i] = sdo;
            sclk_in = 1'b1; cyc(HP); sclk_in = 1'b0;
        end
        cyc(4); rx_frame_n = 1'b1; cyc(6);
    endtask

    // self-clocked frame: is_rd selects read; abort_at>0 releases early
    task automatic self_xfer(input bit is_rd, input logic a, input logic [W-1:0] wi,
                             output logic [W-1:0] wo, input int abort_at);
        logic prev;
        int last;
        addr_sel = a; sdi = wi[W-1]; cyc(2);
        if (is_rd) rx_frame_n = 1'b0; else tx_frame_n = 1'b0;
        n_rise = 0; min_gap = 999; max_gap = 0; prev = 1'b0; last = 0; oe_seen = 0;
        wo = '0;
        for (int t = 0; t < 300; t++) begin
            cyc(1);
            if (sclk_oe) oe_seen = 1;
            if (sclk_out && !prev) begin
                if (n_rise > 0) begin
                    if (t - last < min_gap) min_gap = t - last;
                    if (t - last > max_gap) max_gap = t - last;
                end
                last = t;
                if (is_rd && n_rise < W) wo[W-1-n_rise] = sdo;
                n_rise++;
                if (n_rise < W) sdi = wi[W-1-n_rise];
            end
            prev = sclk_out;
            if (abort_at > 0 && n_rise == abort_at) break;
        end
        if (abort_at == 0) chk("R3 clock released at word end", {31'd0, sclk_oe}, 32'd0);
        if (is_rd) rx_frame_n = 1'b1; else tx_frame_n = 1'b1;
        cyc(6);
    endtask

    initial begin
        cyc(200000);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] rd, w;
        int hi;
        void'($urandom(32'h5EED1234));
        cyc(3); rst_n = 1'b1; cyc(2);

        // R1 reset state
        chk("R1 ctrl reset", {8'd0, ctrl_word}, 32'd0);
        chk("R1 cal reset", {8'd0, cal_word}, 32'd0);
        chk("R1 enables reset", {29'd0, sclk_oe, sdo_oe, filt_rst}, 32'd0);

        // R5 external write to control, R8 data enable idle
        ext_wr(1'b0, 24'hA5C3_0F, W, 0); exp_ctrl = exp_write(24'hA5C30F);
        chk("R5 ext ctrl write", {8'd0, ctrl_word}, {8'd0, exp_ctrl});
        chk("R8 sdo_oe idle", {31'd0, sdo_oe}, 32'd0);

        // R6 calibration write leaves control alone
        ext_wr(1'b1, 24'h13579B, W, 0); exp_cal = 24'h13579B;
        chk("R6 cal write", {8'd0, cal_word}, {8'd0, exp_cal});
        chk("R6 ctrl untouched", {8'd0, ctrl_word}, {8'd0, exp_ctrl});

        // R7 reads of both sides, R8 enable during read
        ext_rd(1'b0, rd);
        chk("R7 read ctrl", {8'd0, rd}, {8'd0, exp_ctrl});
        chk("R8 sdo_oe in read", {31'd0, oe_seen}, 32'd1);
        conv_data = 24'hF0E1D2;
        ext_rd(1'b1, rd);
        chk("R7 read conv_data", {8'd0, rd}, 32'h00F0E1D2);
        chk("R8 sdo_oe after read", {31'd0, sdo_oe}, 32'd0);

        // R9 short frame discarded
        ext_wr(1'b0, 24'h00FFFF, 10, 0);
        chk("R9 short write ignored", {8'd0, ctrl_word}, {8'd0, exp_ctrl});

        // R10 bursty clock with long gaps
        ext_wr(1'b0, 24'h3C3C81, W, 37); exp_ctrl = 24'h3C3C81;
        chk("R10 gapped write", {8'd0, ctrl_word}, {8'd0, exp_ctrl});

        // R11 surplus bits ignored
        ext_wr(1'b1, 24'hBEEF42, 30, 0); exp_cal = 24'hBEEF42;
        chk("R11 surplus bits", {8'd0, cal_word}, {8'd0, exp_cal});

        // R2 external mode never drove clock
        chk("R2 no clock drive ext", {31'd0, sclk_oe}, 32'd0);

        // R3 self-clocked write: count and spacing
        mode_self = 1'b1;
        self_xfer(1'b0, 1'b0, 24'h5A5A11, rd, 0); exp_ctrl = 24'h5A5A11;
        chk("R3 rise count", n_rise, W);
        chk("R3 min period", min_gap, 4);
        chk("R3 max period", max_gap, 4);
        chk("R3 clock was driven", {31'd0, oe_seen}, 32'd1);
        chk("R5 self ctrl write", {8'd0, ctrl_word}, {8'd0, exp_ctrl});

        // R7 self-clocked read
        self_xfer(1'b1, 1'b0, '0, rd, 0);
        chk("R7 self read ctrl", {8'd0, rd}, {8'd0, exp_ctrl});

        // R4 abort mid-word; R9 nothing stored
        self_xfer(1'b0, 1'b1, 24'h777777, rd, 7);
        chk("R4 clock released on abort", {31'd0, sclk_oe}, 32'd0);
        chk("R9 aborted self write", {8'd0, cal_word}, {8'd0, exp_cal});

        // R12 sync pulse length, no retrigger while held
        sync_n = 1'b0; hi = 0;
        for (int i = 0; i < 20; i++) begin cyc(1); if (filt_rst) hi++; end
        chk("R12 pulse length", hi, 4);
        sync_n = 1'b1; cyc(4);

        // random mix of modes, addresses and words
        for (int k = 0; k < 12; k++) begin
            logic a;
            a = 1'($urandom);
            w = W'($urandom);
            mode_self = 1'($urandom);
            if (mode_self) self_xfer(1'b0, a, w, rd, 0);
            else ext_wr(a, w, W, (k % 3) * 5);
            if (a) exp_cal = w; else exp_ctrl = w;
            chk(a ? "R6 random cal" : "R5 random ctrl",
                {8'd0, (a ? cal_word : ctrl_word)}, {8'd0, w});
            conv_data = W'($urandom);
            mode_self = 1'($urandom);
            a = 1'($urandom);
            if (mode_self) self_xfer(1'b1, a, '0, rd, 0);
            else ext_rd(a, rd);
            chk("R7 random read", {8'd0, rd}, {8'd0, (a ? conv_data : exp_ctrl)});
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule